// File: doc/BRIEF.md
# In-order multi-issue scoreboard stage

This block is the issue stage of a configurable superscalar pipeline. Each cycle it looks at a window of up to four decoded instructions, listed oldest first. Each instruction carries a class, a destination register and two source registers. The block grants the longest run of instructions, taken from the oldest end of the window, that passes three checks: every operand is ready, a unit in the instruction's pool is idle, and the per-cycle issue limit has not been reached. Each granted instruction is bound to a specific unit of its pool. The stage that feeds the window drops the granted instructions and presents the rest again, with newer instructions behind them.

Register readiness is tracked with one down-counter per architectural register. Each unit has its own busy down-counter. Result latency is set per class. The number of units and the occupancy time are set per pool. The class tables, the pool tables and the issue limit are parameters. Grants, unit indices and the stall flag are registered, so they appear in the cycle after the window that produced them.

Top module: `sb_issue_stage`

## Requirements
- R1: While reset is asserted and in the first idle cycles after it, all grants are 0, every unit index is 0 and the stall flag is 0. Every register counts as ready and every unit counts as idle.
- R2: Grants always form a prefix of the window: slot 0 is the oldest, and slot k is granted only if slot k-1 is also granted. Only slots marked valid are granted. When a slot cannot issue, no younger slot issues in that cycle.
- R3: No more than MAX_ISSUE slots are granted in one cycle (default 3), even when more units are free.
- R4: A consumer issues only after its producer's result latency L has elapsed. With L=1 it can issue in the next cycle. With L=2 it waits one extra cycle, and with L=3 it waits two.
- R5: Result latency is chosen by class. The default class table is: class 0 = 1 cycle, pool 0; classes 1 and 2 = 2 cycles, pool 1; class 3 = 2 cycles, pool 2; class 4 = 3 cycles, pool 3; classes 5 to 15 = 1 cycle, pool 0.
- R6: A slot that reads the destination of an older slot granted in the same cycle is not granted in that cycle.
- R7: Each granted slot reports the lowest-numbered idle unit of its pool that no older slot in the same group has taken. Two granted slots never share a unit.
- R8: A unit that has just accepted an instruction stays busy for its pool's occupancy time. An occupancy of 1 frees the unit for the next cycle. When every unit of a pool is busy, an instruction for that pool stalls. Default pool sizes are 2, 1, 1 and 2, and default occupancy times are 1, 1, 1 and 2 cycles, for pools 0 to 3.
- R9: A slot whose destination is still pending, or is written by an older slot in the same group, waits.
- R10: The stall flag is 1 exactly when at least one valid slot of the window was not granted.
- R11: Register 0 is always ready. Writing register 0 never creates a dependence.
- R12: A slot that is not granted reports unit index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_valid | input | SLOTS | Slot holds an instruction |
| win_class | input | SLOTS x log2(NCLASS) | Instruction class per slot |
| win_dst | input | SLOTS x log2(NREG) | Destination register per slot |
| win_src_a | input | SLOTS x log2(NREG) | First source register per slot (0 = none) |
| win_src_b | input | SLOTS x log2(NREG) | Second source register per slot (0 = none) |
| iss_grant | output | SLOTS | Registered issue grant per slot |
| iss_unit | output | SLOTS x log2(NUNIT) | Registered unit index within the slot's pool |
| iss_stall | output | 1 | Registered flag: some valid slot was held back |

## Verification
A register counter left too high shows up as a consumer that is granted one or more cycles late. A counter cleared too early shows up as a consumer granted too soon. Either way the error appears in the registered grant of the first window that reads that register. A wrong unit timer shows up either as a unit index that differs from the lowest idle unit or as a grant issued during the occupancy window, in the first cycle the pool is asked for again. Because issue is in order, any of these errors also shifts every later grant of the random mix, so one bad counter spreads into many mismatches within a few cycles.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int LAT_W = 4;
  typedef logic [LAT_W-1:0] lat_t;

  // Counts down towards zero and holds there.
  function automatic lat_t dec_sat(input lat_t v);
    return (v == '0) ? '0 : v - lat_t'(1);
  endfunction
endpackage

// File: rtl/sb_class_decode.sv
module sb_class_decode
  import sb_pkg::*;
#(
  parameter int NCLASS = 16,
  parameter int NPOOL  = 4,
  parameter logic [NCLASS*LAT_W-1:0]         CLASS_LAT    = 64'h1111_1111_1113_2221,
  parameter logic [NCLASS*$clog2(NPOOL)-1:0] CLASS_POOL   = 32'h0000_0394,
  parameter logic [NPOOL*LAT_W-1:0]          POOL_ISS_LAT = 16'h2111
) (
  input  logic [$clog2(NCLASS)-1:0] cls,
  output lat_t                      op_lat,
  output logic [$clog2(NPOOL)-1:0]  pool,
  output lat_t                      occ_lat
);
  localparam int POOL_W = $clog2(NPOOL);

  always_comb begin
    op_lat  = CLASS_LAT[int'(cls)*LAT_W +: LAT_W];
    pool    = CLASS_POOL[int'(cls)*POOL_W +: POOL_W];
    occ_lat = POOL_ISS_LAT[int'(pool)*LAT_W +: LAT_W];
  end
endmodule

// File: rtl/sb_reg_timers.sv
module sb_reg_timers
  import sb_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int NREG  = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [SLOTS-1:0]                 load_en,
  input  logic [SLOTS-1:0][$clog2(NREG)-1:0] load_reg,
  input  logic [SLOTS-1:0][LAT_W-1:0]      load_lat,
  output logic [NREG-1:0]                  reg_ready
);
  assign reg_ready[0] = 1'b1;

  for (genvar r = 1; r < NREG; r++) begin : g_reg
    lat_t cnt_q, cnt_d;
    logic cnt_en;

    always_comb begin
      cnt_d  = dec_sat(cnt_q);
      cnt_en = (cnt_q != '0);
      for (int s = 0; s < SLOTS; s++) begin
        if (load_en[s] && int'(load_reg[s]) == r) begin
          cnt_d  = load_lat[s] - lat_t'(1);
          cnt_en = 1'b1;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (cnt_en) cnt_q <= cnt_d;
    end

    assign reg_ready[r] = (cnt_q == '0);
  end
endmodule

// File: rtl/sb_unit_timers.sv
module sb_unit_timers
  import sb_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int NPOOL = 4,
  parameter int NUNIT = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [SLOTS-1:0]                   load_en,
  input  logic [SLOTS-1:0][$clog2(NPOOL)-1:0] load_pool,
  input  logic [SLOTS-1:0][$clog2(NUNIT)-1:0] load_unit,
  input  logic [SLOTS-1:0][LAT_W-1:0]        load_lat,
  output logic [NPOOL-1:0][NUNIT-1:0]        unit_idle
);
  for (genvar p = 0; p < NPOOL; p++) begin : g_pool
    for (genvar u = 0; u < NUNIT; u++) begin : g_unit
      lat_t busy_q, busy_d;
      logic busy_en;

      always_comb begin
        busy_d  = dec_sat(busy_q);
        busy_en = (busy_q != '0);
        for (int s = 0; s < SLOTS; s++) begin
          if (load_en[s] && int'(load_pool[s]) == p && int'(load_unit[s]) == u) begin
            busy_d  = load_lat[s] - lat_t'(1);
            busy_en = 1'b1;
          end
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       busy_q <= '0;
        else if (busy_en) busy_q <= busy_d;
      end

      assign unit_idle[p][u] = (busy_q == '0);
    end
  end
endmodule

// File: rtl/sb_issue_pick.sv
module sb_issue_pick #(
  parameter int SLOTS     = 4,
  parameter int NREG      = 32,
  parameter int NPOOL     = 4,
  parameter int NUNIT     = 4,
  parameter int MAX_ISSUE = 3,
  parameter logic [NPOOL*($clog2(NUNIT)+1)-1:0] POOL_MULT = 12'h44A
) (
  input  logic [SLOTS-1:0]                    valid,
  input  logic [SLOTS-1:0][$clog2(NREG)-1:0]  dst,
  input  logic [SLOTS-1:0][$clog2(NREG)-1:0]  src_a,
  input  logic [SLOTS-1:0][$clog2(NREG)-1:0]  src_b,
  input  logic [SLOTS-1:0][$clog2(NPOOL)-1:0] pool,
  input  logic [NREG-1:0]                     reg_ready,
  input  logic [NPOOL-1:0][NUNIT-1:0]         unit_idle,
  output logic [SLOTS-1:0]                    grant,
  output logic [SLOTS-1:0][$clog2(NUNIT)-1:0] unit
);
  localparam int UNIT_W = $clog2(NUNIT);
  localparam int MULT_W = UNIT_W + 1;
  localparam int CNT_W  = $clog2(SLOTS + 1);

  logic [NPOOL-1:0][NUNIT-1:0] taken;
  logic                        blocked;
  logic                        ok;
  logic                        found;
  logic [UNIT_W-1:0]           pick;
  logic [CNT_W-1:0]            n_iss;

  always_comb begin
    grant   = '0;
    unit    = '0;
    taken   = '0;
    blocked = 1'b0;
    n_iss   = '0;
    ok      = 1'b0;
    found   = 1'b0;
    pick    = '0;
    for (int s = 0; s < SLOTS; s++) begin
      ok = valid[s] && !blocked && (n_iss < CNT_W'(MAX_ISSUE));
      ok = ok && reg_ready[src_a[s]] && reg_ready[src_b[s]] && reg_ready[dst[s]];
      // same-group producers: latency is at least one, so never together
      for (int i = 0; i < s; i++) begin
        if (grant[i] && dst[i] != '0 &&
            (dst[i] == src_a[s] || dst[i] == src_b[s] || dst[i] == dst[s]))
          ok = 1'b0;
      end
      found = 1'b0;
      pick  = '0;
      for (int u = 0; u < NUNIT; u++) begin
        if (!found && u < int'(POOL_MULT[int'(pool[s])*MULT_W +: MULT_W]) &&
            unit_idle[pool[s]][u] && !taken[pool[s]][u]) begin
          found = 1'b1;
          pick  = UNIT_W'(u);
        end
      end
      if (ok && found) begin
        grant[s]              = 1'b1;
        unit[s]               = pick;
        taken[pool[s]][pick]  = 1'b1;
        n_iss                 = n_iss + CNT_W'(1);
      end else begin
        blocked = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sb_issue_stage.sv
module sb_issue_stage
  import sb_pkg::*;
#(
  parameter int SLOTS     = 4,
  parameter int NREG      = 32,
  parameter int NCLASS    = 16,
  parameter int NPOOL     = 4,
  parameter int NUNIT     = 4,
  parameter int MAX_ISSUE = 3,
  parameter logic [NCLASS*LAT_W-1:0]               CLASS_LAT    = 64'h1111_1111_1113_2221,
  parameter logic [NCLASS*$clog2(NPOOL)-1:0]       CLASS_POOL   = 32'h0000_0394,
  parameter logic [NPOOL*($clog2(NUNIT)+1)-1:0]    POOL_MULT    = 12'h44A,
  parameter logic [NPOOL*LAT_W-1:0]                POOL_ISS_LAT = 16'h2111
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [SLOTS-1:0]                    win_valid,
  input  logic [SLOTS-1:0][$clog2(NCLASS)-1:0] win_class,
  input  logic [SLOTS-1:0][$clog2(NREG)-1:0]  win_dst,
  input  logic [SLOTS-1:0][$clog2(NREG)-1:0]  win_src_a,
  input  logic [SLOTS-1:0][$clog2(NREG)-1:0]  win_src_b,
  output logic [SLOTS-1:0]                    iss_grant,
  output logic [SLOTS-1:0][$clog2(NUNIT)-1:0] iss_unit,
  output logic                                iss_stall
);
  localparam int POOL_W = $clog2(NPOOL);
  localparam int UNIT_W = $clog2(NUNIT);

  logic [SLOTS-1:0][LAT_W-1:0]  slot_lat;
  logic [SLOTS-1:0][LAT_W-1:0]  slot_occ;
  logic [SLOTS-1:0][POOL_W-1:0] slot_pool;
  logic [NREG-1:0]              reg_ready;
  logic [NPOOL-1:0][NUNIT-1:0]  unit_idle;
  logic [SLOTS-1:0]             pick_grant;
  logic [SLOTS-1:0][UNIT_W-1:0] pick_unit;
  logic [SLOTS-1:0]             wr_en;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    sb_class_decode #(
      .NCLASS(NCLASS), .NPOOL(NPOOL), .CLASS_LAT(CLASS_LAT),
      .CLASS_POOL(CLASS_POOL), .POOL_ISS_LAT(POOL_ISS_LAT)
    ) u_dec (
      .cls(win_class[s]), .op_lat(slot_lat[s]),
      .pool(slot_pool[s]), .occ_lat(slot_occ[s])
    );
    assign wr_en[s] = pick_grant[s] && (win_dst[s] != '0);
  end

  sb_reg_timers #(.SLOTS(SLOTS), .NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n), .load_en(wr_en), .load_reg(win_dst),
    .load_lat(slot_lat), .reg_ready(reg_ready)
  );

  sb_unit_timers #(.SLOTS(SLOTS), .NPOOL(NPOOL), .NUNIT(NUNIT)) u_units (
    .clk(clk), .rst_n(rst_n), .load_en(pick_grant), .load_pool(slot_pool),
    .load_unit(pick_unit), .load_lat(slot_occ), .unit_idle(unit_idle)
  );

  sb_issue_pick #(
    .SLOTS(SLOTS), .NREG(NREG), .NPOOL(NPOOL), .NUNIT(NUNIT),
    .MAX_ISSUE(MAX_ISSUE), .POOL_MULT(POOL_MULT)
  ) u_pick (
    .valid(win_valid), .dst(win_dst), .src_a(win_src_a), .src_b(win_src_b),
    .pool(slot_pool), .reg_ready(reg_ready), .unit_idle(unit_idle),
    .grant(pick_grant), .unit(pick_unit)
  );

  logic [SLOTS-1:0]             grant_d;
  logic [SLOTS-1:0][UNIT_W-1:0] unit_d;
  logic                         stall_d;

  always_comb begin
    grant_d = pick_grant;
    unit_d  = pick_unit;
    stall_d = |(win_valid & ~pick_grant);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iss_grant <= '0;
      iss_unit  <= '0;
      iss_stall <= 1'b0;
    end else begin
      iss_grant <= grant_d;
      iss_unit  <= unit_d;
      iss_stall <= stall_d;
    end
  end
endmodule

// File: rtl/sb_issue_stage_chk.sv
module sb_issue_stage_chk #(
  parameter int SLOTS     = 4,
  parameter int NCLASS    = 16,
  parameter int NPOOL     = 4,
  parameter int NUNIT     = 4,
  parameter int MAX_ISSUE = 3,
  parameter logic [NCLASS*$clog2(NPOOL)-1:0] CLASS_POOL = 32'h0000_0394
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic [SLOTS-1:0]                    win_valid,
  input logic [SLOTS-1:0][$clog2(NCLASS)-1:0] win_class,
  input logic [SLOTS-1:0]                    iss_grant,
  input logic [SLOTS-1:0][$clog2(NUNIT)-1:0] iss_unit,
  input logic                                iss_stall
);
  localparam int POOL_W = $clog2(NPOOL);

  logic [SLOTS-1:0]                     valid_q;
  logic [SLOTS-1:0][$clog2(NCLASS)-1:0] class_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      class_q <= '0;
    end else begin
      valid_q <= win_valid;
      class_q <= win_class;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (iss_grant == '0 && !iss_stall);
    end
  end

  a_r3_issue_cap: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(iss_grant) <= MAX_ISSUE);

  a_r10_stall_partial: assert property (@(posedge clk) disable iff (!rst_n)
    iss_stall |-> (iss_grant != valid_q));

  a_r10_no_stall_full: assert property (@(posedge clk) disable iff (!rst_n)
    (!iss_stall && valid_q[0]) |-> iss_grant[0]);

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    a_r2_valid_only: assert property (@(posedge clk) disable iff (!rst_n)
      iss_grant[s] |-> valid_q[s]);
    a_r12_idle_unit_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !iss_grant[s] |-> (iss_unit[s] == '0));
    if (s > 0) begin : g_prefix
      a_r2_prefix: assert property (@(posedge clk) disable iff (!rst_n)
        iss_grant[s] |-> iss_grant[s-1]);
    end
  end

  for (genvar i = 0; i < SLOTS; i++) begin : g_pi
    for (genvar j = i + 1; j < SLOTS; j++) begin : g_pj
      a_r7_distinct_units: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_grant[i] && iss_grant[j] &&
         CLASS_POOL[int'(class_q[i])*POOL_W +: POOL_W] ==
         CLASS_POOL[int'(class_q[j])*POOL_W +: POOL_W])
        |-> (iss_unit[i] != iss_unit[j]));
    end
  end
endmodule

bind sb_issue_stage sb_issue_stage_chk #(
  .SLOTS(SLOTS), .NCLASS(NCLASS), .NPOOL(NPOOL), .NUNIT(NUNIT),
  .MAX_ISSUE(MAX_ISSUE), .CLASS_POOL(CLASS_POOL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_class(win_class),
  .iss_grant(iss_grant), .iss_unit(iss_unit), .iss_stall(iss_stall)
);

// File: tb/sb_issue_stage_bench.sv
module sb_issue_stage_bench;
  logic clk = 1'b0;
  logic rst_n;
  always #5 clk = ~clk;

  logic [3:0]      win_valid;
  logic [3:0][3:0] win_class;
  logic [3:0][4:0] win_dst, win_src_a, win_src_b;
  logic [3:0]      iss_grant;
  logic [3:0][1:0] iss_unit;
  logic            iss_stall;

  sb_issue_stage u_sb_issue_stage (
    .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_class(win_class),
    .win_dst(win_dst), .win_src_a(win_src_a), .win_src_b(win_src_b),
    .iss_grant(iss_grant), .iss_unit(iss_unit), .iss_stall(iss_stall)
  );

  typedef struct { logic [3:0] g; logic [3:0][1:0] u; logic st; string tag; } exp_t;
  typedef struct { int cls; int dst; int sa; int sb; } ins_t;

  exp_t expq[$];
  ins_t prog[$];
  exp_t cur;
  int   n_cmp = 0, n_bad = 0;
  bit   done = 0;
  int   m_cnt[32];
  int   m_busy[4][4];
  int   w_v[4], w_cls[4], w_dst[4], w_sa[4], w_sb[4];

  // R5 class table, R8 pool table
  function automatic int cls_lat(int c);
    if (c == 0) return 1;
    if (c >= 1 && c <= 3) return 2;
    if (c == 4) return 3;
    return 1;
  endfunction
  function automatic int cls_pool(int c);
    if (c == 1 || c == 2) return 1;
    if (c == 3) return 2;
    if (c == 4) return 3;
    return 0;
  endfunction
  function automatic int pool_size(int p);
    return (p == 0 || p == 3) ? 2 : 1;
  endfunction
  function automatic int pool_occ(int p);
    return (p == 3) ? 2 : 1;
  endfunction
  function automatic bit rdy(int r);
    return (r == 0) || (m_cnt[r] == 0);
  endfunction

  task automatic model_step(input string tag, output int ng);
    exp_t e;
    int   n;
    bit   stop;
    bit   taken[4][4];
    e.g = '0; e.u = '0; e.st = 1'b0; e.tag = tag;
    n = 0; stop = 0;
    for (int p = 0; p < 4; p++) for (int u = 0; u < 4; u++) taken[p][u] = 0;
    for (int s = 0; s < 4; s++) begin
      bit ok;
      int p;
      int pick;
      ok = 0; p = cls_pool(w_cls[s]); pick = -1;
      if (!stop) begin
        ok = (w_v[s] != 0) && (n < 3);
        ok = ok && rdy(w_sa[s]) && rdy(w_sb[s]) && rdy(w_dst[s]);
        for (int i = 0; i < s; i++)
          if (e.g[i] && w_dst[i] != 0 &&
              (w_dst[i] == w_sa[s] || w_dst[i] == w_sb[s] || w_dst[i] == w_dst[s])) ok = 0;
        for (int u = 0; u < pool_size(p); u++)
          if (pick < 0 && m_busy[p][u] == 0 && !taken[p][u]) pick = u;
        if (ok && pick >= 0) begin
          e.g[s] = 1'b1; e.u[s] = 2'(pick); taken[p][pick] = 1; n++;
        end else stop = 1;
      end
      if (w_v[s] != 0 && !e.g[s]) e.st = 1'b1;
    end
    expq.push_back(e);
    ng = n;
    for (int r = 1; r < 32; r++) if (m_cnt[r] > 0) m_cnt[r]--;
    for (int p = 0; p < 4; p++) for (int u = 0; u < 4; u++) if (m_busy[p][u] > 0) m_busy[p][u]--;
    for (int s = 0; s < 4; s++) if (e.g[s]) begin
      if (w_dst[s] != 0) m_cnt[w_dst[s]] = cls_lat(w_cls[s]) - 1;
      m_busy[cls_pool(w_cls[s])][e.u[s]] = pool_occ(cls_pool(w_cls[s])) - 1;
    end
  endtask

  task automatic one_cycle(input string tag, output int ng);
    @(negedge clk);
    for (int s = 0; s < 4; s++) begin
      if (s < prog.size()) begin
        w_v[s] = 1; w_cls[s] = prog[s].cls; w_dst[s] = prog[s].dst;
        w_sa[s] = prog[s].sa; w_sb[s] = prog[s].sb;
      end else begin
        w_v[s] = 0; w_cls[s] = 0; w_dst[s] = 0; w_sa[s] = 0; w_sb[s] = 0;
      end
      win_valid[s] = (w_v[s] != 0);
      win_class[s] = 4'(w_cls[s]);
      win_dst[s]   = 5'(w_dst[s]);
      win_src_a[s] = 5'(w_sa[s]);
      win_src_b[s] = 5'(w_sb[s]);
    end
    model_step(tag, ng);
  endtask

  task automatic run_prog(input string tag);
    int ng;
    int guard;
    guard = 0;
    while (prog.size() > 0 && guard < 2000) begin
      one_cycle(tag, ng);
      for (int k = 0; k < ng; k++) void'(prog.pop_front());
      guard++;
    end
    for (int k = 0; k < 4; k++) one_cycle(tag, ng);
  endtask

  task automatic add(input int c, input int d, input int a, input int b);
    ins_t x;
    x.cls = c; x.dst = d; x.sa = a; x.sb = b;
    prog.push_back(x);
  endtask

  // monitor: compares the registered outputs after each edge
  always @(posedge clk) begin
    #2;
    if (expq.size() > 0) begin
      cur = expq.pop_front();
      n_cmp++;
      if (iss_grant !== cur.g || iss_unit !== cur.u || iss_stall !== cur.st) begin
        n_bad++;
        $display("FAIL %s: grant %b unit %h stall %b, expected grant %b unit %h stall %b",
                 cur.tag, iss_grant, iss_unit, iss_stall, cur.g, cur.u, cur.st);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all requirements): still running, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    for (int r = 0; r < 32; r++) m_cnt[r] = 0;
    for (int p = 0; p < 4; p++) for (int u = 0; u < 4; u++) m_busy[p][u] = 0;
    win_valid = '0; win_class = '0; win_dst = '0; win_src_a = '0; win_src_b = '0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    #20;
    n_cmp++;
    if (iss_grant !== 4'b0 || iss_unit !== 8'h0 || iss_stall !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 in reset: grant %b unit %h stall %b, expected all zero",
               iss_grant, iss_unit, iss_stall);
    end
    @(negedge clk) rst_n = 1'b1;

    run_prog("R1 idle after reset");

    // R3: four free units across pools, limit of three
    add(0,1,0,0); add(0,2,0,0); add(1,3,0,0); add(3,4,0,0);
    run_prog("R3 cap");

    // R6: reader of a same-group producer waits
    add(0,1,0,0); add(0,2,1,0); add(0,3,0,0);
    run_prog("R6 in-group dependence");

    // R4 and R5: latency 2 (load) and 3 (float) before consumers
    add(1,6,0,0); add(0,7,6,6);
    run_prog("R4 R5 load latency");
    add(4,8,0,0); add(0,9,0,8);
    run_prog("R4 R5 float latency");
    add(0,10,0,0);
    run_prog("R4 latency one");
    add(0,11,10,0);
    run_prog("R4 next cycle use");

    // R8 and R7: occupancy and lowest idle unit
    add(4,12,0,0); add(4,13,0,0); add(4,14,0,0);
    run_prog("R7 R8 float pool");
    add(1,15,0,0); add(2,0,0,0); add(1,16,0,0);
    run_prog("R8 single unit pool");

    // R9: write after pending write
    add(4,17,0,0); add(0,17,0,0);
    run_prog("R9 pending destination");

    // R11: register 0
    add(0,0,0,0); add(0,0,0,0); add(0,0,0,0);
    run_prog("R11 writes to r0");
    add(0,0,0,0); add(0,1,0,0);
    run_prog("R11 r0 reader");

    // R12 and R10 under pool pressure
    add(3,2,0,0); add(3,3,0,0); add(0,4,0,0);
    run_prog("R10 R12 branch pool");

    // random mix over few registers
    seed = 32'h1234_5678;
    for (int k = 0; k < 400; k++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      add(int'(seed[30:28]) % 6, int'(seed[20:18]), int'(seed[15:13]), int'(seed[10:8]));
    end
    run_prog("MIX R2 R4 R7 R8 R9");

    repeat (3) @(posedge clk);
    #4;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule